// File: doc/BRIEF.md
# UART Interrupt Identification and Status Unit

This block is the interrupt and status core of a 16550-style serial port. It receives event signals from the receive FIFO, the transmitter and the modem lines. It keeps the sticky line-error flags, the modem status register and a pending transmit-empty event. From these it selects the single highest-priority interrupt cause and presents it as the identification byte and a level interrupt output.

It also runs the receive character-timeout counter. It applies the side effects that software reads and writes have on these registers. When loopback is enabled, it feeds the modem-control outputs back as modem-status inputs. The FIFOs, the baud generator and the serial shifters belong to neighbouring blocks. Those blocks drive this unit through single-cycle pulses and level inputs.

Top module: `uart_irq_status`

## Requirements
- R1: `iir_val` is `{2'b11, 2'b00, code}`. The code is chosen in this priority order, highest first: 0x6 line error, 0x4 receive data, 0xC character timeout, 0x2 transmit empty, 0x0 modem change. It is 0x1 when no enabled cause is active.
- R2: `irq` is high exactly when `iir_val[0]` is 0.
- R3: The line-error cause (0x6) is active when `ier_en[2]` is set and any of `line_err[3:0]` is set.
- R4: The receive-data cause (0x4) is active when `ier_en[0]` and `rx_ready` are set and `rx_level` is at or above the trigger level. `fcr_trig` values 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14.
- R5: The timeout counter advances by one on each clock with `tick` and `rx_ready` high, and saturates at its maximum. It returns to 0 on any clock with `rx_read` or `rx_char_add`, and this clear takes precedence over counting. The timeout cause (0xC) is active when `ier_en[0]` is set, `rx_level` is nonzero and the count is at least 4 times `char_time`.
- R6: A `thre_set` pulse makes a transmit-empty event pending. The pending event raises cause 0x2 while `ier_en[1]` is set.
- R7: A pending transmit-empty event is cleared when `iir_rd` or `thr_write` arrives while the presented code is 0x2. A `thre_set` in the same cycle wins over the clear.
- R8: Each `err_set` bit is sticky in `line_err` at the same position: bit0 overrun, bit1 parity, bit2 framing, bit3 break. Any error also sets `line_err[4]`, the FIFO-error bit. `lsr_rd` clears all five bits on the next clock. Errors arriving in the same cycle as the read are kept.
- R9: `msr_val[7:4]` hold DCD, RI, DSR and CTS, updated one clock after their source. Outside loopback the source is `modem_in` (bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD). In loopback CTS follows `mcr_out[1]` (RTS), DSR follows `mcr_out[0]` (DTR), RI follows `mcr_out[2]` (OUT1) and DCD follows `mcr_out[3]` (OUT2).
- R10: `msr_val[0]`, `[1]` and `[3]` latch any change of CTS, DSR and DCD. `msr_val[2]` latches only a 1-to-0 change of RI. `msr_rd` clears these four bits on the next clock. A change in the same cycle still sets its bit.
- R11: The modem cause (0x0) is active when `ier_en[3]` is set and any of `msr_val[3:0]` is set.
- R12: After reset `iir_val` is 0xC1, `irq` is 0, `line_err` is 0 and `msr_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_en | input | 4 | Cause enables: bit0 receive data and timeout, bit1 transmit empty, bit2 line error, bit3 modem |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_ready | input | 1 | Receive data ready |
| rx_read | input | 1 | Pulse: receive buffer read |
| rx_char_add | input | 1 | Pulse: character added to receive FIFO |
| tick | input | 1 | Timeout counting strobe |
| char_time | input | CT_W | Character duration in ticks |
| fcr_trig | input | 2 | Trigger level select |
| err_set | input | 4 | Pulses: overrun, parity, framing, break |
| thre_set | input | 1 | Pulse: holding register became empty |
| thr_write | input | 1 | Pulse: holding register written |
| iir_rd | input | 1 | Pulse: identification register read |
| lsr_rd | input | 1 | Pulse: line status read |
| msr_rd | input | 1 | Pulse: modem status read |
| loop_en | input | 1 | Loopback mode |
| mcr_out | input | 4 | Modem control: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2 |
| modem_in | input | 4 | Modem lines: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD |
| iir_val | output | 8 | Interrupt identification byte |
| irq | output | 1 | Level interrupt request |
| line_err | output | 5 | Sticky line errors, bit4 FIFO error |
| msr_val | output | 8 | Modem status |

## Verification
The stimulus is long random runs. In these, the enable mask, trigger selection, fill level and loopback mode change in phases, and events arrive as sparse pulses. This places several causes active together, so priority mistakes show up as a wrong code rather than passing unnoticed.

Directed sequences cover several boundaries:
- fill levels one below and exactly at each trigger level, which separate the threshold compare from an off-by-one;
- a quiet receiver left to reach the timeout threshold, then cleared by a read;
- reads that coincide with new events, which tell set-wins from clear-wins;
- an RI line falling and rising in loopback, which shows that only the falling edge is latched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        CAUSE_MODEM   = 4'h0,
        CAUSE_NONE    = 4'h1,
        CAUSE_THRE    = 4'h2,
        CAUSE_RXDATA  = 4'h4,
        CAUSE_LINE    = 4'h6,
        CAUSE_TIMEOUT = 4'hC
    } cause_e;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        logic fifo_err;
        logic brk;
        logic frame;
        logic parity;
        logic overrun;
    } line_err_t;

    localparam logic [1:0] IIR_TOP_BITS = 2'b11;

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    trig_level = 5'd1;
            2'd1:    trig_level = 5'd4;
            2'd2:    trig_level = 5'd8;
            default: trig_level = 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uis_line_status.sv
module uis_line_status
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] err_set,
    input  logic       lsr_rd,
    output line_err_t  errs
);
    line_err_t nxt;

    always_comb begin
        nxt = lsr_rd ? '0 : errs;
        nxt.overrun  = nxt.overrun  | err_set[0];
        nxt.parity   = nxt.parity   | err_set[1];
        nxt.frame    = nxt.frame    | err_set[2];
        nxt.brk      = nxt.brk      | err_set[3];
        nxt.fifo_err = nxt.fifo_err | (|err_set);
    end

    always_ff @(posedge clk) begin
        if (rst) errs <= '0;
        else     errs <= nxt;
    end
endmodule

// File: rtl/uis_modem_status.sv
module uis_modem_status
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       loop_en,
    input  logic [3:0] mcr_out,
    input  logic [3:0] modem_in,
    input  logic       msr_rd,
    output logic [7:0] msr_val
);
    modem_lines_t src, lines;
    logic [3:0]   delta, chg;

    always_comb begin
        if (loop_en) begin
            src.cts = mcr_out[1];
            src.dsr = mcr_out[0];
            src.ri  = mcr_out[2];
            src.dcd = mcr_out[3];
        end else begin
            src = modem_lines_t'(modem_in);
        end
        chg[0] = src.cts ^ lines.cts;
        chg[1] = src.dsr ^ lines.dsr;
        chg[2] = lines.ri & ~src.ri;
        chg[3] = src.dcd ^ lines.dcd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines <= '0;
            delta <= '0;
        end else begin
            lines <= src;
            delta <= (msr_rd ? 4'b0 : delta) | chg;
        end
    end

    assign msr_val = {lines.dcd, lines.ri, lines.dsr, lines.cts, delta};
endmodule

// File: rtl/uis_rx_timeout.sv
module uis_rx_timeout #(
    parameter int CT_W    = 12,
    parameter int TO_MULT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            rx_ready,
    input  logic            rx_read,
    input  logic            rx_char_add,
    input  logic [CT_W-1:0] char_time,
    output logic            expired
);
    localparam int CNT_W = CT_W + $clog2(TO_MULT) + 1;

    logic [CNT_W-1:0] cnt, limit;

    assign limit   = CNT_W'(char_time) * CNT_W'(TO_MULT);
    assign expired = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (rx_read || rx_char_add)  cnt <= '0;
        else if (tick && rx_ready && !(&cnt)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uis_cause_sel.sv
module uis_cause_sel
    import uart_irq_pkg::*;
(
    input  logic [3:0] ier_en,
    input  logic       line_hit,
    input  logic       rxdata_hit,
    input  logic       timeout_hit,
    input  logic       thre_pend,
    input  logic       modem_hit,
    output cause_e     cause
);
    always_comb begin
        if (ier_en[2] && line_hit)          cause = CAUSE_LINE;
        else if (ier_en[0] && rxdata_hit)   cause = CAUSE_RXDATA;
        else if (ier_en[0] && timeout_hit)  cause = CAUSE_TIMEOUT;
        else if (ier_en[1] && thre_pend)    cause = CAUSE_THRE;
        else if (ier_en[3] && modem_hit)    cause = CAUSE_MODEM;
        else                                cause = CAUSE_NONE;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int CT_W    = 12,
    parameter int TO_MULT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ier_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_ready,
    input  logic             rx_read,
    input  logic             rx_char_add,
    input  logic             tick,
    input  logic [CT_W-1:0]  char_time,
    input  logic [1:0]       fcr_trig,
    input  logic [3:0]       err_set,
    input  logic             thre_set,
    input  logic             thr_write,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             loop_en,
    input  logic [3:0]       mcr_out,
    input  logic [3:0]       modem_in,
    output logic [7:0]       iir_val,
    output logic             irq,
    output logic [4:0]       line_err,
    output logic [7:0]       msr_val
);
    line_err_t errs;
    cause_e    cause;
    logic      to_expired, thre_pend, thre_clr, rxdata_hit, timeout_hit;

    uis_line_status u_line (
        .clk(clk), .rst(rst), .err_set(err_set), .lsr_rd(lsr_rd), .errs(errs)
    );

    uis_modem_status u_modem (
        .clk(clk), .rst(rst), .loop_en(loop_en), .mcr_out(mcr_out),
        .modem_in(modem_in), .msr_rd(msr_rd), .msr_val(msr_val)
    );

    uis_rx_timeout #(.CT_W(CT_W), .TO_MULT(TO_MULT)) u_tmo (
        .clk(clk), .rst(rst), .tick(tick), .rx_ready(rx_ready),
        .rx_read(rx_read), .rx_char_add(rx_char_add),
        .char_time(char_time), .expired(to_expired)
    );

    assign rxdata_hit  = rx_ready && (int'(rx_level) >= int'(trig_level(fcr_trig)));
    assign timeout_hit = to_expired && (rx_level != '0);

    uis_cause_sel u_sel (
        .ier_en(ier_en), .line_hit(|errs[3:0]), .rxdata_hit(rxdata_hit),
        .timeout_hit(timeout_hit), .thre_pend(thre_pend),
        .modem_hit(|msr_val[3:0]), .cause(cause)
    );

    assign thre_clr = (iir_rd || thr_write) && (cause == CAUSE_THRE);

    always_ff @(posedge clk) begin
        if (rst) thre_pend <= 1'b0;
        else     thre_pend <= thre_set || (thre_pend && !thre_clr);
    end

    assign iir_val  = {IIR_TOP_BITS, 2'b00, cause};
    assign irq      = ~cause[0];
    assign line_err = errs;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       ier_en,
    input logic [LVL_W-1:0] rx_level,
    input logic [3:0]       err_set,
    input logic             thre_set,
    input logic             iir_rd,
    input logic             lsr_rd,
    input logic [7:0]       iir_val,
    input logic             irq,
    input logic [4:0]       line_err,
    input logic [7:0]       msr_val
);
    p_top_bits_r1: assert property (@(posedge clk) disable iff (rst)
        iir_val[7:4] == 4'b1100);

    p_irq_level_r2: assert property (@(posedge clk) disable iff (rst)
        irq == !iir_val[0]);

    p_line_first_r3: assert property (@(posedge clk) disable iff (rst)
        (ier_en[2] && |line_err[3:0]) |-> iir_val[3:0] == 4'h6);

    p_timeout_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
        (iir_val[3:0] == 4'hC) |-> rx_level != '0);

    p_thre_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && iir_val[3:0] == 4'h2 && !thre_set) |=> iir_val[3:0] != 4'h2);

    p_lsr_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && err_set == 4'b0) |=> line_err == 5'b0);

    p_ri_trailing_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_val[2]) |-> ($past(msr_val[6]) && !msr_val[6]));
endmodule

bind uart_irq_status uart_irq_status_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .ier_en(ier_en), .rx_level(rx_level),
    .err_set(err_set), .thre_set(thre_set), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .iir_val(iir_val), .irq(irq), .line_err(line_err), .msr_val(msr_val)
);

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
    localparam int LVL_W = 5;
    localparam int CT_W  = 12;
    localparam int CNT_MAX = (1 << (CT_W + 3)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] ier_en = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic rx_ready = 0, rx_read = 0, rx_char_add = 0, tick = 0;
    logic [CT_W-1:0] char_time = 12'd3;
    logic [1:0] fcr_trig = '0;
    logic [3:0] err_set = '0;
    logic thre_set = 0, thr_write = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0, loop_en = 0;
    logic [3:0] mcr_out = '0, modem_in = '0;
    logic [7:0] iir_val, msr_val;
    logic irq;
    logic [4:0] line_err;

    int checks = 0, errors = 0;

    logic [4:0] m_err;
    logic       m_thre;
    logic [3:0] m_lines, m_delta;
    int         m_cnt;

    always #4 clk = ~clk;

    uart_irq_status #(.LVL_W(LVL_W), .CT_W(CT_W), .TO_MULT(4)) u_dut (
        .clk(clk), .rst(rst), .ier_en(ier_en), .rx_level(rx_level),
        .rx_ready(rx_ready), .rx_read(rx_read), .rx_char_add(rx_char_add),
        .tick(tick), .char_time(char_time), .fcr_trig(fcr_trig),
        .err_set(err_set), .thre_set(thre_set), .thr_write(thr_write),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .loop_en(loop_en),
        .mcr_out(mcr_out), .modem_in(modem_in), .iir_val(iir_val), .irq(irq),
        .line_err(line_err), .msr_val(msr_val)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] exp_code();
        if (ier_en[2] && |m_err[3:0]) return 4'h6;
        if (ier_en[0] && rx_ready && int'(rx_level) >= trig_of(fcr_trig)) return 4'h4;
        if (ier_en[0] && rx_level != 0 && m_cnt >= 4 * int'(char_time)) return 4'hC;
        if (ier_en[1] && m_thre) return 4'h2;
        if (ier_en[3] && |m_delta) return 4'h0;
        return 4'h1;
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h6: return "R3";
            4'h4: return "R4";
            4'hC: return "R5";
            4'h2: return "R6 R7";
            4'h0: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_err = '0; m_thre = 0; m_lines = '0; m_delta = '0; m_cnt = 0;
    endtask

    // Inputs are already set (driven after a falling edge); check, then step.
    task automatic cycle();
        logic [3:0] ec, src, chg;
        #1;
        ec = exp_code();
        chk(req_of(ec), iir_val, {4'hC, ec});
        chk("R2", {7'b0, irq}, {7'b0, ~ec[0]});
        chk("R8", {3'b0, line_err}, {3'b0, m_err});
        chk("R9", {4'b0, msr_val[7:4]}, {4'b0, m_lines});
        chk("R10", {4'b0, msr_val[3:0]}, {4'b0, m_delta});
        @(posedge clk);
        // error flags
        if (lsr_rd) m_err = '0;
        m_err[3:0] = m_err[3:0] | err_set;
        if (|err_set) m_err[4] = 1'b1;
        // transmit-empty event
        m_thre = thre_set || (m_thre && !((iir_rd || thr_write) && ec == 4'h2));
        // modem lines
        src = loop_en ? {mcr_out[3], mcr_out[2], mcr_out[0], mcr_out[1]} : modem_in;
        chg = {src[3] ^ m_lines[3], m_lines[2] & ~src[2], src[1] ^ m_lines[1], src[0] ^ m_lines[0]};
        m_delta = (msr_rd ? 4'b0 : m_delta) | chg;
        m_lines = src;
        // timeout counter
        if (rx_read || rx_char_add) m_cnt = 0;
        else if (tick && rx_ready && m_cnt < CNT_MAX) m_cnt++;
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        rx_read = 0; rx_char_add = 0; err_set = '0; thre_set = 0;
        thr_write = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R12: reset values
        chk("R12", iir_val, 8'hC1);
        chk("R12", {7'b0, irq}, 8'h00);
        chk("R12", {3'b0, line_err}, 8'h00);
        chk("R12", msr_val, 8'h00);
        @(negedge clk);

        // R4: trigger thresholds, one below and at each level
        ier_en = 4'b0001; rx_ready = 1; tick = 0;
        for (int s = 0; s < 4; s++) begin
            fcr_trig = 2'(s);
            rx_level = 5'(trig_of(2'(s)) - 1); cycle();
            rx_level = 5'(trig_of(2'(s)));     cycle();
        end
        fcr_trig = 2'd3; rx_level = 5'd14; #1;
        chk("R4", iir_val, 8'hC4);
        @(negedge clk);

        // R5: timeout reached on a quiet receiver, then cleared by a read
        rx_level = 5'd2; fcr_trig = 2'd3; tick = 1; char_time = 12'd3;
        repeat (14) cycle();
        #1; chk("R5", iir_val, 8'hCC);
        @(negedge clk);
        rx_read = 1; cycle(); rx_read = 0;
        tick = 0; cycle();
        #1; chk("R5", iir_val, 8'hC1);
        @(negedge clk);

        // R6 R7: event, clear by IIR read, and set-wins on a coincident read
        rx_ready = 0; rx_level = 0; ier_en = 4'b0010;
        thre_set = 1; cycle(); thre_set = 0; cycle();
        iir_rd = 1; thre_set = 1; cycle(); iir_rd = 0; thre_set = 0; cycle();
        thr_write = 1; cycle(); thr_write = 0; cycle();
        #1; chk("R7", iir_val, 8'hC1);
        @(negedge clk);

        // R8 R3: error sticky, read coinciding with new error
        ier_en = 4'b1111;
        err_set = 4'b0100; cycle(); err_set = 0; cycle();
        lsr_rd = 1; err_set = 4'b0001; cycle(); lsr_rd = 0; err_set = 0; cycle();
        lsr_rd = 1; cycle(); lsr_rd = 0; cycle();

        // R9 R10: loopback with RI falling then rising
        loop_en = 1; mcr_out = 4'b0100; cycle(); cycle();
        msr_rd = 1; cycle(); msr_rd = 0; cycle();
        mcr_out = 4'b0000; cycle(); cycle();
        msr_rd = 1; cycle(); msr_rd = 0;
        mcr_out = 4'b0100; cycle(); cycle();
        mcr_out = 4'b1011; cycle(); cycle();
        loop_en = 0; cycle();

        // random phases
        for (int i = 0; i < 6000; i++) begin
            clear_pulses();
            if (i % 150 == 0) begin
                ier_en = 4'($urandom);
                fcr_trig = 2'($urandom);
                char_time = 12'(2 + $urandom % 3);
            end
            if (i % 700 == 0) loop_en = 1'($urandom);
            if ($urandom % 8 == 0) rx_level = 5'($urandom % 17);
            rx_ready = (rx_level != 0);
            tick = ($urandom % 10) < 7;
            rx_read = ($urandom % 20) == 0;
            rx_char_add = ($urandom % 25) == 0;
            if ($urandom % 30 == 0) err_set = 4'($urandom);
            thre_set = ($urandom % 25) == 0;
            thr_write = ($urandom % 15) == 0;
            iir_rd = ($urandom % 6) == 0;
            lsr_rd = ($urandom % 12) == 0;
            msr_rd = ($urandom % 12) == 0;
            if ($urandom % 20 == 0) mcr_out = 4'($urandom);
            if ($urandom % 20 == 0) modem_in = 4'($urandom);
            cycle();
        end

        clear_pulses();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule